// File: doc/BRIEF.md
# Sticky Interrupt Controller for Multi-Channel Regulator Events

This block gathers event pulses and condition levels from several regulator channels and from chip-level sources and holds each one in a latched flag bit. A single active-low interrupt line, `irq_n_o`, goes low while any flag that is not masked is pending. Software reads and clears the flags, and sets the masks, through a simple register port. The port has a write strobe, an address and a write byte. Read data is combinational from the address.

Each channel has three flags: current limit, short circuit and power-good. Each channel also rolls up into a read-only summary bit in the top register. The top register also holds the thermal-warning, thermal-shutdown, load-measurement-ready and reset-cause flags. A clear does not take effect while its level condition is still present. The reset-cause flag comes up set after any of three things: a pin reset, an undervoltage-recovery pulse, or a software reset. Each of these also returns every other register to its default.

Register map (byte wide):
- Address 0 holds the top flags. Bits [NCH-1:0] are the channel summaries. Bit 4 is thermal warning, bit 5 is thermal shutdown, bit 6 is load ready and bit 7 is the reset cause.
- Address 1 holds the top masks at bits 4, 6 and 7.
- Address 2 holds the top live status: bit 4 is thermal warning and bit 5 is thermal shutdown.
- Writing 0x01 to address 3 requests a software reset.
- Channel c starts at address 8+4c. Offset 0 holds the flags, offset 1 the masks and offset 2 the live status. Within each of these, bit 0 is current limit, bit 1 is short circuit and bit 2 is power-good.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: A current-limit level, a short-circuit pulse, a power-good rising edge, a thermal-warning level, a thermal-shutdown level or a load-ready pulse sets its flag at the next clock edge. After that edge `irq_n_o` reads 0 when the flag is unmasked.
- R2: `irq_n_o` stays 0 while at least one unmasked flag is pending. It returns to 1 only after the last unmasked flag has been cleared.
- R3: Writing 1 to a flag bit clears it at that clock edge. Writing 0 leaves it unchanged.
- R4: A clear of the current-limit, thermal-warning or thermal-shutdown flag has no effect while its input level is still 1.
- R5: Top bit c (c < NCH) reads as the OR of channel c's three flags. Writes to it are ignored, and it reads 0 once the channel flags are cleared.
- R6: Mask bits exist for current limit (channel bit 0), power-good (channel bit 2), thermal warning (top bit 4), load ready (top bit 6) and reset cause (top bit 7). Short circuit and thermal shutdown have no mask: their mask positions read 0 and always let the flag drive `irq_n_o`. A masked flag still sets and reads back, but it does not pull `irq_n_o` low.
- R7: Live-status bits follow the current-limit, power-good, thermal-warning and thermal-shutdown inputs at the same bit positions as their flags, whatever the flags hold.
- R8: After `rst_n` is released, after a `uv_recover_i` pulse, and after a write of 0x01 to address 3, the reset-cause flag (top bit 7) is 1. All other flags and all masks are 0 at that point.
- R9: When a flag's set condition and a write-one clear of that flag arrive at the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ilim_i | input | NCH | Current-limit level per channel |
| sc_i | input | NCH | Short-circuit event pulse per channel |
| pg_i | input | NCH | Power-good level per channel |
| twarn_i | input | 1 | Thermal-warning level |
| tsd_i | input | 1 | Thermal-shutdown level |
| lrdy_i | input | 1 | Load-measurement-ready pulse |
| uv_recover_i | input | 1 | Undervoltage-recovery pulse, acts as a soft reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The assertions check four things on every cycle:
- a set overrides a same-edge clear;
- a current-limit or thermal-shutdown level leaves its flag standing at the next edge, whatever clear was written;
- any soft reset leaves the reset-cause flag set and the masks at zero;
- a pending short-circuit flag always holds the interrupt low.

The bench's scenarios are needed for the rest:
- the roll-up of channel flags into summary bits;
- the read-only behaviour of those summary bits;
- masked flags that latch silently;
- the interrupt staying low until the last of several flags is gone;
- the read-back of live status.

// File: rtl/irq_pkg.sv
// Package: register addresses and bit positions shared by the
// sticky interrupt controller and its sub-blocks.
package irq_pkg;
    localparam int RW          = 8;   // register width
    localparam int A_TOP_FLAG  = 0;
    localparam int A_TOP_MASK  = 1;
    localparam int A_TOP_STAT  = 2;
    localparam int A_SWRST     = 3;
    localparam int A_CH_BASE   = 8;
    localparam int A_CH_STRIDE = 4;
    localparam int O_FLAG      = 0;
    localparam int O_MASK      = 1;
    localparam int O_STAT      = 2;
    // channel bit positions
    localparam int CB_ILIM     = 0;
    localparam int CB_SC       = 1;
    localparam int CB_PG       = 2;
    localparam int CH_NF       = 3;
    // top bit positions
    localparam int TB_TWARN    = 4;
    localparam int TB_TSD      = 5;
    localparam int TB_LRDY     = 6;
    localparam int TB_RST      = 7;
    localparam int TOP_NF      = 4;
    localparam logic [RW-1:0] SWRST_KEY = 8'h01;
endpackage

// File: rtl/irq_flag_cell.sv
// Module: one sticky flag bit.
// Sets when set_i is high and clears on clr_i; when both arrive together the set wins.
// Assumes a synchronous active-low reset, plus a soft reset that has the same effect.
module irq_flag_cell #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // hold the flag, with set taking priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) q_o <= INIT;
        else                      q_o <= set_i | (q_o & ~clr_i);
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !soft_rst_i) |=> q_o);
endmodule

// File: rtl/irq_chan_regs.sv
// Module: the flag, mask and live-status bytes of one regulator channel.
// Assumes a level current-limit input, a pulsed short-circuit input and
// a level power-good input whose rising edge sets the power-good flag.
module irq_chan_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              ilim_i,
    input  logic              sc_i,
    input  logic              pg_i,
    input  logic              flag_wr_i,
    input  logic              mask_wr_i,
    input  logic [CH_NF-1:0]  wdata_i,
    output logic [RW-1:0]     flags_o,
    output logic [RW-1:0]     mask_o,
    output logic [RW-1:0]     stat_o,
    output logic              irq_req_o,
    output logic              summary_o
);
    logic             pg_q;
    logic             m_ilim, m_pg;
    logic [CH_NF-1:0] set_v, flag_v, mask_v;

    // remember the last power-good level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) pg_q <= 1'b0;
        else                      pg_q <= pg_i;
    end

    // mask bits exist only for current limit and power-good
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            m_ilim <= 1'b0;
            m_pg   <= 1'b0;
        end else if (mask_wr_i) begin
            m_ilim <= wdata_i[CB_ILIM];
            m_pg   <= wdata_i[CB_PG];
        end
    end

    // set conditions of each flag
    always_comb begin
        set_v          = '0;
        set_v[CB_ILIM] = ilim_i;
        set_v[CB_SC]   = sc_i;
        set_v[CB_PG]   = pg_i & ~pg_q;
        mask_v          = '0;
        mask_v[CB_ILIM] = m_ilim;
        mask_v[CB_PG]   = m_pg;
    end

    for (genvar b = 0; b < CH_NF; b++) begin : g_flag
        irq_flag_cell #(.INIT(1'b0)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst_i (soft_rst_i),
            .set_i      (set_v[b]),
            .clr_i      (flag_wr_i & wdata_i[b]),
            .q_o        (flag_v[b])
        );
    end

    // build the readable bytes and the interrupt request
    always_comb begin
        flags_o          = '0;
        flags_o[CH_NF-1:0] = flag_v;
        mask_o           = '0;
        mask_o[CH_NF-1:0]  = mask_v;
        stat_o           = '0;
        stat_o[CB_ILIM]  = ilim_i;
        stat_o[CB_PG]    = pg_i;
        irq_req_o        = |(flag_v & ~mask_v);
        summary_o        = |flag_v;
    end

    // R4
    ilim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_i && !soft_rst_i) |=> flags_o[CB_ILIM]);
endmodule

// File: rtl/irq_top_regs.sv
// Module: the chip-level flags (thermal warning, thermal shutdown, load ready,
// reset cause), their masks and live status.
// Assumes level thermal inputs and a pulsed load-ready input.
// The reset-cause flag is preset by any reset.
module irq_top_regs
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst_i,
    input  logic               twarn_i,
    input  logic               tsd_i,
    input  logic               lrdy_i,
    input  logic               flag_wr_i,
    input  logic               mask_wr_i,
    input  logic [TOP_NF-1:0]  wdata_i,   // write byte bits [7:4]
    output logic [RW-1:0]      flags_o,   // bits [7:4] only
    output logic [RW-1:0]      mask_o,
    output logic [RW-1:0]      stat_o,
    output logic               irq_req_o
);
    localparam int          LB   = TB_TWARN;      // lowest top bit
    localparam logic [TOP_NF-1:0] INITV = 4'b1000; // reset-cause preset

    logic [TOP_NF-1:0] set_v, flag_v, mask_v;
    logic m_twarn, m_lrdy, m_rst;

    // masks for thermal warning, load ready and reset cause
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            m_twarn <= 1'b0;
            m_lrdy  <= 1'b0;
            m_rst   <= 1'b0;
        end else if (mask_wr_i) begin
            m_twarn <= wdata_i[TB_TWARN-LB];
            m_lrdy  <= wdata_i[TB_LRDY-LB];
            m_rst   <= wdata_i[TB_RST-LB];
        end
    end

    // set conditions and mask vector
    always_comb begin
        set_v                = '0;
        set_v[TB_TWARN-LB]   = twarn_i;
        set_v[TB_TSD-LB]     = tsd_i;
        set_v[TB_LRDY-LB]    = lrdy_i;
        mask_v               = '0;
        mask_v[TB_TWARN-LB]  = m_twarn;
        mask_v[TB_LRDY-LB]   = m_lrdy;
        mask_v[TB_RST-LB]    = m_rst;
    end

    for (genvar b = 0; b < TOP_NF; b++) begin : g_flag
        irq_flag_cell #(.INIT(INITV[b])) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst_i (soft_rst_i),
            .set_i      (set_v[b]),
            .clr_i      (flag_wr_i & wdata_i[b]),
            .q_o        (flag_v[b])
        );
    end

    // place the fields in the readable bytes
    always_comb begin
        flags_o               = '0;
        flags_o[RW-1:LB]      = flag_v;
        mask_o                = '0;
        mask_o[RW-1:LB]       = mask_v;
        stat_o                = '0;
        stat_o[TB_TWARN]      = twarn_i;
        stat_o[TB_TSD]        = tsd_i;
        irq_req_o             = |(flag_v & ~mask_v);
    end

    // R4
    tsd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tsd_i && !soft_rst_i) |=> flags_o[TB_TSD]);

    // R8
    soft_reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (flags_o[TB_RST] && mask_o == '0));
endmodule

// File: rtl/sticky_irq_ctrl.sv
// Module: top of the sticky interrupt controller.
// Decodes the register port, instantiates one register set per channel plus
// the chip-level set, builds the summary bits and drives the active-low interrupt.
// Assumes NCH <= 4, so that the summary bits fit below the chip-level flags.
module sticky_irq_ctrl
    import irq_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int AW  = $clog2(A_CH_BASE + A_CH_STRIDE * NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ilim_i,
    input  logic [NCH-1:0] sc_i,
    input  logic [NCH-1:0] pg_i,
    input  logic           twarn_i,
    input  logic           tsd_i,
    input  logic           lrdy_i,
    input  logic           uv_recover_i,
    input  logic           reg_we_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic [RW-1:0]  reg_wdata_i,
    output logic [RW-1:0]  reg_rdata_o,
    output logic           irq_n_o
);
    int            addr;
    logic          soft_rst;
    logic          top_irq;
    logic [RW-1:0] top_flags, top_mask, top_stat;
    logic [RW-1:0] ch_flags [NCH];
    logic [RW-1:0] ch_mask  [NCH];
    logic [RW-1:0] ch_stat  [NCH];
    logic [NCH-1:0] ch_irq, ch_sum;

    assign addr = int'(reg_addr_i);

    // undervoltage recovery or the software-reset key both act as a soft reset
    assign soft_rst = uv_recover_i |
                      (reg_we_i && addr == A_SWRST && reg_wdata_i == SWRST_KEY);

    irq_top_regs u_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .twarn_i    (twarn_i),
        .tsd_i      (tsd_i),
        .lrdy_i     (lrdy_i),
        .flag_wr_i  (reg_we_i && addr == A_TOP_FLAG),
        .mask_wr_i  (reg_we_i && addr == A_TOP_MASK),
        .wdata_i    (reg_wdata_i[RW-1:TB_TWARN]),
        .flags_o    (top_flags),
        .mask_o     (top_mask),
        .stat_o     (top_stat),
        .irq_req_o  (top_irq)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int BASE = A_CH_BASE + A_CH_STRIDE * c;
        irq_chan_regs u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst_i (soft_rst),
            .ilim_i     (ilim_i[c]),
            .sc_i       (sc_i[c]),
            .pg_i       (pg_i[c]),
            .flag_wr_i  (reg_we_i && addr == BASE + O_FLAG),
            .mask_wr_i  (reg_we_i && addr == BASE + O_MASK),
            .wdata_i    (reg_wdata_i[CH_NF-1:0]),
            .flags_o    (ch_flags[c]),
            .mask_o     (ch_mask[c]),
            .stat_o     (ch_stat[c]),
            .irq_req_o  (ch_irq[c]),
            .summary_o  (ch_sum[c])
        );

        // R6
        sc_unmaskable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_flags[c][CB_SC] |-> !irq_n_o);
    end

    // read multiplexer: summary bits are merged into the top flag byte
    always_comb begin
        reg_rdata_o = '0;
        if (addr == A_TOP_FLAG) begin
            reg_rdata_o = top_flags;
            for (int c = 0; c < NCH; c++) reg_rdata_o[c] = ch_sum[c];
        end else if (addr == A_TOP_MASK) begin
            reg_rdata_o = top_mask;
        end else if (addr == A_TOP_STAT) begin
            reg_rdata_o = top_stat;
        end
        for (int c = 0; c < NCH; c++) begin
            if (addr == A_CH_BASE + A_CH_STRIDE * c + O_FLAG) reg_rdata_o = ch_flags[c];
            if (addr == A_CH_BASE + A_CH_STRIDE * c + O_MASK) reg_rdata_o = ch_mask[c];
            if (addr == A_CH_BASE + A_CH_STRIDE * c + O_STAT) reg_rdata_o = ch_stat[c];
        end
    end

    // shared interrupt line, low while any unmasked flag is pending
    assign irq_n_o = ~(top_irq | (|ch_irq));
endmodule

// File: tb/sticky_irq_ctrl_test.sv
module sticky_irq_ctrl_test;
    localparam int NCH = 4;
    localparam int AW  = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0] ilim = '0, sc = '0, pg = '0;
    logic tw = 1'b0, tsd = 1'b0, lr = 1'b0, uv = 1'b0;
    logic we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic irq_n;
    int errors = 0, checks = 0;
    logic [7:0] v;

    sticky_irq_ctrl #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .ilim_i(ilim), .sc_i(sc), .pg_i(pg),
        .twarn_i(tw), .tsd_i(tsd), .lrdy_i(lr), .uv_recover_i(uv),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_n_o(irq_n));

    always #5 clk = ~clk;

    // vector bits: [3:0] ilim, [7:4] sc, [11:8] pg, 12 tw, 13 tsd, 14 lr
    localparam logic [14:0] VEC [8] = '{15'h0001, 15'h0080, 15'h0200, 15'h1000,
                                        15'h2000, 15'h4000, 15'h0824, 15'h0000};

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        we = 1'b1; addr = AW'(a); wdata = d;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        addr = AW'(a); #1; d = rdata;
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic clear_all();
        wr(0, 8'hFF);
        for (int c = 0; c < NCH; c++) wr(8 + 4 * c, 8'h07);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        rd(0, v); chk("R8 reset top flags", v, 8'h80);
        chk("R8 reset irq_n", {7'd0, irq_n}, 8'h00);
        rd(9, v); chk("R8 reset ch0 mask", v, 8'h00);
        wr(0, 8'h80);
        chk("R2 irq_n after reset flag clear", {7'd0, irq_n}, 8'h01);

        // R1 R5 R3 vector table
        for (int i = 0; i < 8; i++) begin
            logic [7:0] exp_top;
            ilim = VEC[i][3:0]; sc = VEC[i][7:4]; pg = VEC[i][11:8];
            tw = VEC[i][12]; tsd = VEC[i][13]; lr = VEC[i][14];
            tick();
            ilim = '0; sc = '0; pg = '0; tw = 1'b0; tsd = 1'b0; lr = 1'b0;
            exp_top = {1'b0, VEC[i][14], VEC[i][13], VEC[i][12],
                       VEC[i][3:0] | VEC[i][7:4] | VEC[i][11:8]};
            rd(0, v); chk($sformatf("R1 R5 vec%0d top", i), v, exp_top);
            chk($sformatf("R1 vec%0d irq_n", i), {7'd0, irq_n}, {7'd0, exp_top == 8'h00});
            clear_all();
            rd(0, v); chk($sformatf("R3 vec%0d cleared", i), v, 8'h00);
            chk($sformatf("R3 vec%0d irq_n", i), {7'd0, irq_n}, 8'h01);
        end

        // R3 writing 0 has no effect
        sc[0] = 1'b1; tick(); sc[0] = 1'b0;
        wr(8, 8'h00); rd(8, v); chk("R3 write zero", v, 8'h02);
        wr(8, 8'h02); rd(8, v); chk("R3 write one", v, 8'h00);

        // R4 clear blocked while current limit active
        ilim[1] = 1'b1; tick();
        wr(12, 8'h01); rd(12, v); chk("R4 ilim clear blocked", v, 8'h01);
        ilim[1] = 1'b0;
        wr(12, 8'h01); rd(12, v); chk("R4 ilim clear after release", v, 8'h00);

        // R4 R7 thermal warning
        tw = 1'b1; tick();
        wr(0, 8'h10); rd(0, v); chk("R4 twarn clear blocked", v, 8'h10);
        rd(2, v); chk("R7 twarn live", v, 8'h10);
        tw = 1'b0;
        wr(0, 8'h10); rd(0, v); chk("R4 twarn cleared", v, 8'h00);
        rd(2, v); chk("R7 twarn live low", v, 8'h00);

        // R4 thermal shutdown
        tsd = 1'b1; tick();
        wr(0, 8'h20); rd(0, v); chk("R4 tsd clear blocked", v, 8'h20);
        rd(2, v); chk("R7 tsd live", v, 8'h20);
        tsd = 1'b0;
        wr(0, 8'h20); rd(0, v); chk("R4 tsd cleared", v, 8'h00);

        // R7 channel live status
        ilim[2] = 1'b1; pg[0] = 1'b1; tick();
        rd(18, v); chk("R7 ch2 stat", v, 8'h01);
        rd(10, v); chk("R7 ch0 stat", v, 8'h04);
        ilim[2] = 1'b0; pg[0] = 1'b0;
        wr(8, 8'h07); wr(16, 8'h07);
        rd(10, v); chk("R7 ch0 stat low", v, 8'h00);

        // R6 masks
        wr(9, 8'h07); rd(9, v); chk("R6 ch mask readback", v, 8'h05);
        ilim[0] = 1'b1; tick(); ilim[0] = 1'b0;
        rd(8, v); chk("R6 masked flag still set", v, 8'h01);
        chk("R6 masked no irq", {7'd0, irq_n}, 8'h01);
        sc[0] = 1'b1; tick(); sc[0] = 1'b0;
        chk("R6 sc unmaskable", {7'd0, irq_n}, 8'h00);
        wr(8, 8'h07);
        chk("R6 irq released", {7'd0, irq_n}, 8'h01);
        wr(1, 8'hFF); rd(1, v); chk("R6 top mask readback", v, 8'hD0);
        lr = 1'b1; tick(); lr = 1'b0;
        rd(0, v); chk("R6 masked lrdy set", v, 8'h40);
        chk("R6 masked lrdy no irq", {7'd0, irq_n}, 8'h01);
        tsd = 1'b1; tick(); tsd = 1'b0;
        chk("R6 tsd unmaskable", {7'd0, irq_n}, 8'h00);
        wr(0, 8'hFF);
        chk("R6 top cleared irq", {7'd0, irq_n}, 8'h01);
        wr(1, 8'h00); wr(9, 8'h00);

        // R5 summary read-only
        sc[2] = 1'b1; tick(); sc[2] = 1'b0;
        rd(0, v); chk("R5 summary set", v, 8'h04);
        wr(0, 8'h0F); rd(0, v); chk("R5 summary read-only", v, 8'h04);
        wr(16, 8'h02); rd(0, v); chk("R5 summary auto clear", v, 8'h00);

        // R2 irq held until the last flag clears
        sc[0] = 1'b1; lr = 1'b1; tick(); sc[0] = 1'b0; lr = 1'b0;
        wr(0, 8'h40);
        chk("R2 irq still low", {7'd0, irq_n}, 8'h00);
        wr(8, 8'h02);
        chk("R2 irq released", {7'd0, irq_n}, 8'h01);

        // R9 set wins over same-edge clear
        sc[3] = 1'b1; we = 1'b1; addr = AW'(20); wdata = 8'h02;
        tick();
        sc[3] = 1'b0; we = 1'b0;
        rd(20, v); chk("R9 set wins", v, 8'h02);
        wr(20, 8'h02);

        // R8 undervoltage recovery
        wr(1, 8'hD0); sc[1] = 1'b1; tick(); sc[1] = 1'b0;
        uv = 1'b1; tick(); uv = 1'b0;
        rd(1, v); chk("R8 uv masks default", v, 8'h00);
        rd(12, v); chk("R8 uv flags default", v, 8'h00);
        rd(0, v); chk("R8 uv reset flag", v, 8'h80);
        chk("R8 uv irq", {7'd0, irq_n}, 8'h00);
        wr(0, 8'h80);

        // R8 software reset
        wr(9, 8'h05); sc[1] = 1'b1; tick(); sc[1] = 1'b0;
        wr(3, 8'h01);
        rd(9, v); chk("R8 sw mask default", v, 8'h00);
        rd(12, v); chk("R8 sw flags default", v, 8'h00);
        rd(0, v); chk("R8 sw reset flag", v, 8'h80);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule